// File: doc/BRIEF.md
# Four-Channel DMA Controller Register File

This block is the register front end of a four-channel, single-cycle DMA controller that sits on an 8-bit I/O port bus. The host programs each channel's 16-bit start address and transfer count through one byte-wide port per register. A single byte pointer, shared by all channels, chooses which half is reached. The host also programs a per-channel mode byte and the channel masks, and it polls a terminal-count status byte.

The transfer engine is a separate block. It receives each channel's mode fields, its mask bit, and its current address and count. It returns two kinds of one-cycle pulses per channel: a step pulse, which advances the current registers by one transfer, and a terminal-count pulse. On a terminal-count pulse the block records status and, for auto-initialize channels, reloads the current registers from the base registers.

Reads are combinational on `bus_rdata` while `bus_rd` is high. Their side effects (pointer toggle, status clear) take place at the clock edge that ends the read cycle. Reset is synchronous and active high.

Top module: `dmareg_top`

## Requirements
- R1: After reset all four mask bits are 1, the byte pointer selects the low byte, the status bits and all mode fields are 0, and every base and current register is 0.
- R2: Port 2n reaches channel n's address register and port 2n+1 its count register (n = 0..3). A write loads the byte chosen by the pointer into both the base and the current register. A read returns that byte of the current register. Low byte is selected when the pointer is 0, high byte when it is 1.
- R3: The byte pointer is shared by all eight address/count ports and flips after every access to any of them. A write of any value to port 0xB returns it to the low byte.
- R4: A write to port 0x9 sets (data bit 2 = 1) or clears (bit 2 = 0) the mask of the channel given by data bits [1:0]. The other masks are left unchanged.
- R5: A write to port 0xC loads all four masks from data bits [3:0]. A read of port 0xC returns the masks in bits [3:0].
- R6: A write to port 0xA updates only the mode of the channel given by data bits [1:0]. The mode fields are direction [3:2], auto-initialize [4], address decrement [5] and transfer type [7:6].
- R7: A read of port 0x8 returns the terminal-count bits in [3:0] and zero in [7:4]. Each bit is set by that channel's `eng_tc` pulse, holds until a status read, and is cleared at the end of that read.
- R8: A terminal-count pulse in the same cycle as a status read leaves its bit set after the read.
- R9: An `eng_step` pulse decrements the current count by 1 (0x0000 wraps to 0xFFFF). It also moves the current address by +1, or by -1 when the decrement bit is set, wrapping modulo 2^16. Base registers are not affected.
- R10: An `eng_tc` pulse on a channel whose auto-initialize bit is set copies both base registers into the current registers, taking precedence over a step in the same cycle. With auto-initialize clear, the tc pulse leaves the registers unchanged.
- R11: When `bus_wr` and `bus_rd` are both high the read is ignored. `bus_rdata` is 0 whenever no read is in effect and for reads of unmapped ports (0xD..0xF). Writes to ports 0x8, 0xD, 0xE and 0xF change no state.
- R12: A host write to a channel's address or count port discards that cycle's engine step and reload on the same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | I/O port offset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while a read is in effect |
| eng_step | input | 4 | Per-channel transfer-done pulse from the engine |
| eng_tc | input | 4 | Per-channel terminal-count pulse from the engine |
| ch_mask | output | 4 | Per-channel mask, 1 = masked |
| ch_dir | output | 8 | Direction field, 2 bits per channel, channel 0 in [1:0] |
| ch_autoinit | output | 4 | Auto-initialize enable per channel |
| ch_decr | output | 4 | Address decrement per channel |
| ch_xfer | output | 8 | Transfer type field, 2 bits per channel |
| ch_addr | output | 64 | Current address, 16 bits per channel, channel 0 in [15:0] |
| ch_count | output | 64 | Current count, 16 bits per channel |

## Verification
A byte pointer left in the wrong state does not show at once. It appears on the next address or count access, as a byte landing in the wrong half of `ch_addr`/`ch_count` one cycle later, or as the wrong half on `bus_rdata` in the same cycle. A lost or stuck status bit is visible only at the next read of port 0x8. A mistaken reload or step shows on `ch_addr`/`ch_count` in the cycle after the pulse. The mask and mode registers drive ports directly, so any error in them appears in the cycle after the write.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam int CH_BITS = 2;
    localparam int NUM_CH  = 1 << CH_BITS;
    localparam int DATA_W  = 8;
    localparam int REG_W   = 2 * DATA_W;
    localparam int ADDR_W  = 4;
    localparam int CHAN_PORTS = 2 * NUM_CH;

    // Mode byte bits [7:2], top field first
    typedef struct packed {
        logic [1:0] xfer;
        logic       decr;
        logic       autoinit;
        logic [1:0] dir;
    } chan_mode_t;

    typedef enum logic [ADDR_W-1:0] {
        PORT_STATUS = 4'h8,
        PORT_SMASK  = 4'h9,
        PORT_MODE   = 4'hA,
        PORT_PTRCLR = 4'hB,
        PORT_AMASK  = 4'hC
    } port_e;

    typedef struct packed {
        logic               ac_wr;
        logic               ac_rd;
        logic [CH_BITS-1:0] ac_ch;
        logic               ac_cnt;
        logic               smask_wr;
        logic               mode_wr;
        logic               ptrclr_wr;
        logic               amask_wr;
        logic               amask_rd;
        logic               stat_rd;
    } bus_op_t;

    function automatic logic is_chan_port(input logic [ADDR_W-1:0] a);
        return int'(a) < CHAN_PORTS;
    endfunction

    function automatic chan_mode_t mode_from_byte(input logic [DATA_W-1:0] d);
        return chan_mode_t'(d[DATA_W-1:2]);
    endfunction

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
    import dmareg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output bus_op_t           op
);

    logic rd_eff;

    always_comb begin
        rd_eff = rd & ~wr;
        op     = '0;
        if (is_chan_port(addr)) begin
            op.ac_wr  = wr;
            op.ac_rd  = rd_eff;
            op.ac_ch  = addr[CH_BITS:1];
            op.ac_cnt = addr[0];
        end else begin
            case (addr)
                PORT_STATUS: op.stat_rd   = rd_eff;
                PORT_SMASK:  op.smask_wr  = wr;
                PORT_MODE:   op.mode_wr   = wr;
                PORT_PTRCLR: op.ptrclr_wr = wr;
                PORT_AMASK: begin
                    op.amask_wr = wr;
                    op.amask_rd = rd_eff;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
    import dmareg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              is_cnt,
    input  logic              hi_byte,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step,
    input  logic              tc,
    input  chan_mode_t        mode,
    output logic [REG_W-1:0]  cur_addr,
    output logic [REG_W-1:0]  cur_cnt
);

    logic [REG_W-1:0] base_addr;
    logic [REG_W-1:0] base_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
        end else if (host_wr) begin
            if (is_cnt) begin
                if (hi_byte) begin
                    base_cnt[REG_W-1:DATA_W] <= wdata;
                    cur_cnt[REG_W-1:DATA_W]  <= wdata;
                end else begin
                    base_cnt[DATA_W-1:0] <= wdata;
                    cur_cnt[DATA_W-1:0]  <= wdata;
                end
            end else begin
                if (hi_byte) begin
                    base_addr[REG_W-1:DATA_W] <= wdata;
                    cur_addr[REG_W-1:DATA_W]  <= wdata;
                end else begin
                    base_addr[DATA_W-1:0] <= wdata;
                    cur_addr[DATA_W-1:0]  <= wdata;
                end
            end
        end else if (tc && mode.autoinit) begin
            cur_addr <= base_addr;
            cur_cnt  <= base_cnt;
        end else if (step) begin
            cur_addr <= mode.decr ? cur_addr - 1'b1 : cur_addr + 1'b1;
            cur_cnt  <= cur_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/dmareg_ctrl.sv
module dmareg_ctrl
    import dmareg_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  bus_op_t                       op,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [NUM_CH-1:0]             tc,
    output logic                          ptr_hi,
    output logic [NUM_CH-1:0]             mask,
    output logic [NUM_CH-1:0]             stat,
    output chan_mode_t [NUM_CH-1:0]       modes
);

    always_ff @(posedge clk) begin
        if (rst)
            ptr_hi <= 1'b0;
        else if (op.ptrclr_wr)
            ptr_hi <= 1'b0;
        else if (op.ac_wr || op.ac_rd)
            ptr_hi <= ~ptr_hi;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask <= '1;
        else if (op.amask_wr)
            mask <= wdata[NUM_CH-1:0];
        else if (op.smask_wr)
            mask[wdata[CH_BITS-1:0]] <= wdata[CH_BITS];
    end

    always_ff @(posedge clk) begin
        if (rst)
            stat <= '0;
        else
            stat <= (op.stat_rd ? '0 : stat) | tc;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_mode
        always_ff @(posedge clk) begin
            if (rst)
                modes[g] <= '0;
            else if (op.mode_wr && (wdata[CH_BITS-1:0] == CH_BITS'(g)))
                modes[g] <= mode_from_byte(wdata);
        end
    end

endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
    import dmareg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [NUM_CH-1:0]       eng_step,
    input  logic [NUM_CH-1:0]       eng_tc,
    output logic [NUM_CH-1:0]       ch_mask,
    output logic [2*NUM_CH-1:0]     ch_dir,
    output logic [NUM_CH-1:0]       ch_autoinit,
    output logic [NUM_CH-1:0]       ch_decr,
    output logic [2*NUM_CH-1:0]     ch_xfer,
    output logic [REG_W*NUM_CH-1:0] ch_addr,
    output logic [REG_W*NUM_CH-1:0] ch_count
);

    bus_op_t                    op;
    logic                       ptr_hi;
    logic [NUM_CH-1:0]          tc_stat;
    chan_mode_t [NUM_CH-1:0]    modes;
    logic [REG_W-1:0]           cur_a [NUM_CH];
    logic [REG_W-1:0]           cur_c [NUM_CH];
    logic [REG_W-1:0]           rd_word;

    dmareg_decode i_decode (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .op   (op)
    );

    dmareg_ctrl i_ctrl (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .wdata  (bus_wdata),
        .tc     (eng_tc),
        .ptr_hi (ptr_hi),
        .mask   (ch_mask),
        .stat   (tc_stat),
        .modes  (modes)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        dmareg_chan i_chan (
            .clk      (clk),
            .rst      (rst),
            .host_wr  (op.ac_wr && (op.ac_ch == CH_BITS'(g))),
            .is_cnt   (op.ac_cnt),
            .hi_byte  (ptr_hi),
            .wdata    (bus_wdata),
            .step     (eng_step[g]),
            .tc       (eng_tc[g]),
            .mode     (modes[g]),
            .cur_addr (cur_a[g]),
            .cur_cnt  (cur_c[g])
        );

        assign ch_addr[REG_W*g +: REG_W]  = cur_a[g];
        assign ch_count[REG_W*g +: REG_W] = cur_c[g];
        assign ch_dir[2*g +: 2]           = modes[g].dir;
        assign ch_xfer[2*g +: 2]          = modes[g].xfer;
        assign ch_autoinit[g]             = modes[g].autoinit;
        assign ch_decr[g]                 = modes[g].decr;
    end

    always_comb begin
        rd_word   = op.ac_cnt ? cur_c[op.ac_ch] : cur_a[op.ac_ch];
        bus_rdata = '0;
        if (op.ac_rd)
            bus_rdata = ptr_hi ? rd_word[REG_W-1:DATA_W] : rd_word[DATA_W-1:0];
        else if (op.stat_rd)
            bus_rdata = {{(DATA_W-NUM_CH){1'b0}}, tc_stat};
        else if (op.amask_rd)
            bus_rdata = {{(DATA_W-NUM_CH){1'b0}}, ch_mask};
    end

endmodule

// File: rtl/dmareg_chk.sv
module dmareg_chk
    import dmareg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [NUM_CH-1:0] amask_data,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] eng_tc,
    input logic [NUM_CH-1:0] ch_mask,
    input logic              ptr_hi,
    input logic [NUM_CH-1:0] tc_stat
);

    AST_RESET_MASKED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ch_mask == '1)); // R1

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == PORT_PTRCLR) |=> !ptr_hi); // R3

    AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && is_chan_port(bus_addr)) |=> (ptr_hi != $past(ptr_hi))); // R3

    AST_AMASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == PORT_AMASK) |=> (ch_mask == $past(amask_data))); // R5

    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == PORT_STATUS && eng_tc == '0) |=> (tc_stat == '0)); // R7

    AST_STAT_SET: assert property (@(posedge clk) disable iff (rst)
        (eng_tc != '0) |=> ((tc_stat & $past(eng_tc)) == $past(eng_tc))); // R8

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && !bus_wr) |-> (bus_rdata == '0)); // R11

endmodule

bind dmareg_top dmareg_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .amask_data (bus_wdata[dmareg_pkg::NUM_CH-1:0]),
    .bus_rdata  (bus_rdata),
    .eng_tc     (eng_tc),
    .ch_mask    (ch_mask),
    .ptr_hi     (ptr_hi),
    .tc_stat    (tc_stat)
);

// File: tb/test_dmareg_top.sv
module test_dmareg_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  eng_step = '0;
    logic [3:0]  eng_tc = '0;
    logic [3:0]  ch_mask;
    logic [7:0]  ch_dir;
    logic [3:0]  ch_autoinit;
    logic [3:0]  ch_decr;
    logic [7:0]  ch_xfer;
    logic [63:0] ch_addr;
    logic [63:0] ch_count;

    always #10 clk = ~clk;

    dmareg_top i_dmareg_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_step(eng_step), .eng_tc(eng_tc),
        .ch_mask(ch_mask), .ch_dir(ch_dir), .ch_autoinit(ch_autoinit), .ch_decr(ch_decr),
        .ch_xfer(ch_xfer), .ch_addr(ch_addr), .ch_count(ch_count)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // reference state
    logic [15:0] m_badr [4];
    logic [15:0] m_cadr [4];
    logic [15:0] m_bcnt [4];
    logic [15:0] m_ccnt [4];
    logic [7:0]  m_mode [4];
    logic [3:0]  m_mask;
    logic [3:0]  m_stat;
    bit          m_ptr;

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic m_reset();
        for (int i = 0; i < 4; i++) begin
            m_badr[i] = '0; m_cadr[i] = '0; m_bcnt[i] = '0; m_ccnt[i] = '0; m_mode[i] = '0;
        end
        m_mask = 4'hF; m_stat = '0; m_ptr = 0;
    endtask

    function automatic logic [7:0] m_read(input logic [3:0] a);
        logic [15:0] v;
        if (a < 8) begin
            v = a[0] ? m_ccnt[a[2:1]] : m_cadr[a[2:1]];
            return m_ptr ? v[15:8] : v[7:0];
        end
        if (a == 4'h8) return {4'h0, m_stat};
        if (a == 4'hC) return {4'h0, m_mask};
        return 8'h00;
    endfunction

    task automatic m_clock(input bit w, input bit r, input logic [3:0] a, input logic [7:0] d,
                           input logic [3:0] stp, input logic [3:0] tc);
        int wch;
        wch = (w && a < 8) ? int'(a[2:1]) : -1;
        for (int i = 0; i < 4; i++) begin
            if (i == wch) continue;
            if (tc[i] && m_mode[i][4]) begin
                m_cadr[i] = m_badr[i];
                m_ccnt[i] = m_bcnt[i];
            end else if (stp[i]) begin
                m_cadr[i] = m_mode[i][5] ? m_cadr[i] - 16'd1 : m_cadr[i] + 16'd1;
                m_ccnt[i] = m_ccnt[i] - 16'd1;
            end
        end
        if (w) begin
            if (a < 8) begin
                if (a[0]) begin
                    if (m_ptr) begin m_bcnt[wch][15:8] = d; m_ccnt[wch][15:8] = d; end
                    else       begin m_bcnt[wch][7:0]  = d; m_ccnt[wch][7:0]  = d; end
                end else begin
                    if (m_ptr) begin m_badr[wch][15:8] = d; m_cadr[wch][15:8] = d; end
                    else       begin m_badr[wch][7:0]  = d; m_cadr[wch][7:0]  = d; end
                end
                m_ptr = !m_ptr;
            end else if (a == 4'h9) m_mask[d[1:0]] = d[2];
            else if (a == 4'hA) m_mode[d[1:0]] = {d[7:2], 2'b00};
            else if (a == 4'hB) m_ptr = 0;
            else if (a == 4'hC) m_mask = d[3:0];
        end else if (r) begin
            if (a < 8) m_ptr = !m_ptr;
            else if (a == 4'h8) m_stat = '0;
        end
        m_stat = m_stat | tc;
    endtask

    task automatic cmp_outputs(input string tag);
        logic [7:0]  e_dir, e_xfer;
        logic [3:0]  e_auto, e_decr;
        logic [63:0] e_addr, e_cnt;
        for (int i = 0; i < 4; i++) begin
            e_dir[2*i +: 2]   = m_mode[i][3:2];
            e_auto[i]         = m_mode[i][4];
            e_decr[i]         = m_mode[i][5];
            e_xfer[2*i +: 2]  = m_mode[i][7:6];
            e_addr[16*i +: 16] = m_cadr[i];
            e_cnt[16*i +: 16]  = m_ccnt[i];
        end
        check(tag, "mask", 64'(ch_mask), 64'(m_mask));
        check(tag, "dir", 64'(ch_dir), 64'(e_dir));
        check(tag, "autoinit", 64'(ch_autoinit), 64'(e_auto));
        check(tag, "decr", 64'(ch_decr), 64'(e_decr));
        check(tag, "xfer", 64'(ch_xfer), 64'(e_xfer));
        check(tag, "addr", ch_addr, e_addr);
        check(tag, "count", ch_count, e_cnt);
    endtask

    // one bus cycle: drive after the falling edge, compare read data before the
    // rising edge, advance the model at the edge, compare outputs at the next fall
    task automatic cyc(input string tag, input bit w, input bit r, input logic [3:0] a,
                       input logic [7:0] d, input logic [3:0] stp = 4'h0, input logic [3:0] tc = 4'h0);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; eng_step = stp; eng_tc = tc;
        #1;
        check(tag, "rdata", 64'(bus_rdata), (r && !w) ? 64'(m_read(a)) : 64'h0);
        @(posedge clk);
        m_clock(w, r, a, d, stp, tc);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; eng_step = '0; eng_tc = '0;
        cmp_outputs(tag);
    endtask

    task automatic wr(input string tag, input logic [3:0] a, input logic [7:0] d);
        cyc(tag, 1, 0, a, d);
    endtask

    task automatic rd(input string tag, input logic [3:0] a);
        cyc(tag, 0, 1, a, 8'h00);
    endtask

    task automatic wr16(input string tag, input logic [3:0] a, input logic [15:0] v);
        wr(tag, a, v[7:0]);
        wr(tag, a, v[15:8]);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        cmp_outputs("R1");
        rd("R1", 4'h8);
        rd("R1", 4'hC);
        rd("R1", 4'h1);
        rd("R1", 4'h1);

        // R2: 16-bit register access, low then high
        wr16("R2", 4'h0, 16'h1234);
        wr16("R2", 4'h7, 16'hBEEF);
        rd("R2", 4'h0); rd("R2", 4'h0);
        rd("R2", 4'h7); rd("R2", 4'h7);

        // R3: shared pointer and clear port
        wr("R3", 4'h2, 8'hAA);
        wr("R3", 4'h5, 8'h55);
        wr("R3", 4'h4, 8'h11);
        wr("R3", 4'hB, 8'hFF);
        wr("R3", 4'h4, 8'h22);
        rd("R3", 4'h4);
        wr("R3", 4'hB, 8'h00);
        rd("R3", 4'h4);
        rd("R3", 4'h2);

        // R4 / R5: masks
        wr("R4", 4'h9, 8'h02);
        wr("R4", 4'h9, 8'hF8);
        wr("R4", 4'h9, 8'h01);
        rd("R4", 4'hC);
        wr("R4", 4'h9, 8'h04);
        wr("R5", 4'hC, 8'hF5);
        rd("R5", 4'hC);
        wr("R5", 4'hC, 8'h00);

        // R6: modes
        wr("R6", 4'hA, 8'h04);
        wr("R6", 4'hA, 8'h69);
        wr("R6", 4'hA, 8'h56);
        wr("R6", 4'hA, 8'hFF);
        wr("R6", 4'hA, 8'h3B);

        // R9: steps, incrementing ch0 and decrementing ch1/ch3, count wrap
        wr("R9", 4'hB, 8'h00);
        wr16("R9", 4'h2, 16'h0001);
        wr16("R9", 4'h3, 16'h0002);
        wr16("R9", 4'h6, 16'hFFFF);
        wr16("R9", 4'h7, 16'h0000);
        cyc("R9", 0, 0, 4'hF, 8'h00, 4'b1011, 4'h0);
        cyc("R9", 0, 0, 4'hF, 8'h00, 4'b0010, 4'h0);
        cyc("R9", 0, 0, 4'hF, 8'h00, 4'b0010, 4'h0);
        rd("R9", 4'h3); rd("R9", 4'h3);

        // R10: auto-init reload on ch2, no reload on ch0 and ch1
        wr("R10", 4'hA, 8'h56);
        wr16("R10", 4'h4, 16'h8000);
        wr16("R10", 4'h5, 16'h0010);
        cyc("R10", 0, 0, 4'hF, 8'h00, 4'b0100, 4'h0);
        cyc("R10", 0, 0, 4'hF, 8'h00, 4'b0100, 4'h0);
        cyc("R10", 0, 0, 4'hF, 8'h00, 4'b0111, 4'b0111);

        // R7 / R8: sticky status, cleared by read, pulse during read survives
        cyc("R7", 0, 0, 4'hF, 8'h00, 4'h0, 4'b1000);
        rd("R7", 4'h8);
        rd("R7", 4'h8);
        cyc("R8", 0, 1, 4'h8, 8'h00, 4'h0, 4'b0010);
        rd("R8", 4'h8);
        rd("R8", 4'h8);

        // R11: read ignored under write, unmapped ports
        rd("R11", 4'hD);
        rd("R11", 4'hF);
        wr("R11", 4'hE, 8'hFF);
        wr("R11", 4'h8, 8'hFF);
        cyc("R11", 1, 1, 4'h1, 8'h77);
        cyc("R11", 1, 1, 4'h8, 8'h00, 4'h0, 4'b0001);
        rd("R11", 4'h8);
        rd("R11", 4'h1);

        // R12: host write beats engine on the same channel only
        wr("R12", 4'hB, 8'h00);
        cyc("R12", 1, 0, 4'h2, 8'h40, 4'b0011, 4'h0);
        cyc("R12", 1, 0, 4'h5, 8'h00, 4'b0100, 4'b0100);
        rd("R12", 4'h2); rd("R12", 4'h2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule